// File: doc/BRIEF.md
# Dual-CPU Interrupt Routing Matrix

The block connects a set of level-sensitive peripheral interrupt request lines to the 32 interrupt inputs of each of two CPUs. Every source has a separate 5-bit route register for each CPU. That register names the CPU interrupt line the source drives. All sources routed to the same line are ORed together. Only some line numbers are wired to the CPU. Routing a source to one of the other numbers switches that source off.

Each CPU has a mask input. While it is high, every source routed to that CPU's non-maskable line is held off. Software can also read the synchronized level of every source through per-CPU status words. This lets it see which sources are requesting, whatever their routing. Access is through a single-cycle register bus with combinational read data.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every route register reads 6 and all 32 lines of both CPUs are low.
- R2: A source routed to a wired number n drives bit n of that CPU's line vector. The wired numbers are 0–5, 8–10, 12–14, 17–28 and 30–31. A source level change appears on the line at the third rising clock edge after it is applied, and not at the second.
- R3: A source routed to number 6, 7, 11, 15, 16 or 29 drives no line of that CPU, and the choice among these numbers makes no difference.
- R4: Routing a source on one CPU does not change the other CPU's lines or route registers.
- R5: When several sources share one wired number, that line is high while any of them is high and low only when all are low.
- R6: While a CPU's mask input is high, the line numbered NMI_LINE (default 14) of that CPU is held low from the next rising edge. The line recovers on the next edge after release. Other lines and the other CPU are unaffected.
- R7: Status word w of CPU c is at word address 2*NUM_SRC + c*ceil(NUM_SRC/32) + w. Its bit b shows the synchronized level of source 32*w+b, two edges after the input changes, before routing or masking. Both CPUs show the same levels. Writes to status addresses change nothing.
- R8: The route register of CPU c, source s is at word address c*NUM_SRC + s and holds write-data bits [4:0]. It reads back with bits [31:5] zero. A write takes effect on the line outputs one edge after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_irq_i | input | NUM_SRC | Peripheral interrupt levels, asynchronous |
| nmi_mask_i | input | 2 | Per-CPU mask for the non-maskable line |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| cpu0_irq_o | output | 32 | CPU 0 interrupt lines, registered |
| cpu1_irq_o | output | 32 | CPU 1 interrupt lines, registered |

## Verification
One source is swept through every wired and every internal-only number. This separates the connected line set from the disabled set, and confirms that no internal number leaks onto any line. Two sources are then routed to a common line and dropped one at a time, which shows the OR of the shared sources. The same source is routed differently on each CPU, so any crosstalk between the two CPUs shows up. The mask is toggled while a masked line and an unmasked line are both active on one CPU and the same line is active on the other CPU, which isolates the masking to one line of one CPU. Latency is sampled one edge early and on the expected edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_CPU   = 2;
  localparam int LINE_W    = 5;
  localparam int NUM_LINES = 1 << LINE_W;
  localparam int WORD_W    = 32;
  // lines 6,7,11,15,16,29 are not wired to the CPU
  localparam logic [NUM_LINES-1:0] WIRED_LINES = 32'hDFFE_773F;
  localparam logic [LINE_W-1:0]    ROUTE_RESET = 5'd6;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // cycles since reset, saturating, so $past(…,2) never reaches before reset
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (sync_q == $past(async_i, 2)));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [ADDR_W-1:0]                        addr_i,
  input  logic                                     we_i,
  input  logic [WORD_W-1:0]                        wdata_i,
  input  logic [NUM_SRC-1:0]                       lvl_i,
  output logic [NUM_CPU*NUM_SRC-1:0][LINE_W-1:0]   route_o,
  output logic [WORD_W-1:0]                        rdata_o
);
  localparam int ROUTE_WORDS = NUM_CPU * NUM_SRC;
  localparam int IDX_W       = $clog2(ROUTE_WORDS);
  localparam int STAT_WORDS  = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int STAT_BASE   = ROUTE_WORDS;
  localparam int STAT_END    = STAT_BASE + NUM_CPU * STAT_WORDS;

  logic [ROUTE_WORDS-1:0][LINE_W-1:0] route_q, route_d;
  logic [STAT_WORDS*WORD_W-1:0]       lvl_pad;
  logic                               route_hit;
  logic [IDX_W-1:0]                   idx;

  assign route_hit = (int'(addr_i) < ROUTE_WORDS);
  assign idx       = addr_i[IDX_W-1:0];
  assign lvl_pad   = (STAT_WORDS*WORD_W)'(lvl_i);

  always_comb begin
    route_d = route_q;
    if (we_i && route_hit) route_d[idx] = wdata_i[LINE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= {ROUTE_WORDS{ROUTE_RESET}};
    else        route_q <= route_d;
  end

  always_comb begin
    int off;
    rdata_o = '0;
    off     = int'(addr_i) - STAT_BASE;
    if (route_hit) begin
      rdata_o = WORD_W'(route_q[idx]);
    end else if (int'(addr_i) < STAT_END) begin
      rdata_o = lvl_pad[(off % STAT_WORDS)*WORD_W +: WORD_W];
    end
  end

  assign route_o = route_q;

  p_route_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we_i && route_hit) |-> (route_q[$past(idx)] == $past(wdata_i[LINE_W-1:0])));

  p_status_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we_i && !route_hit) |-> $stable(route_q));
endmodule

// File: rtl/irq_fanin.sv
module irq_fanin
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NMI_LINE = 14
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              lvl_i,
  input  logic [NUM_SRC-1:0][LINE_W-1:0]  route_i,
  input  logic                            nmi_mask_i,
  output logic [NUM_LINES-1:0]            lines_o
);
  logic [NUM_LINES-1:0] hit, gate, lines_d, lines_q;

  always_comb begin
    hit = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (lvl_i[s]) hit[route_i[s]] = 1'b1;
    end
    gate = WIRED_LINES;
    if (nmi_mask_i) gate[NMI_LINE] = 1'b0;
    lines_d = hit & gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines_d;
  end

  assign lines_o = lines_q;

  p_nmi_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_mask_i) |-> !lines_q[NMI_LINE]);

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lvl_i) == '0) |-> (lines_q == '0));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NMI_LINE = 14,
  parameter int ADDR_W   = $clog2(NUM_CPU*NUM_SRC + NUM_CPU*((NUM_SRC+31)/32))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_irq_i,
  input  logic [1:0]          nmi_mask_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [31:0]         cpu0_irq_o,
  output logic [31:0]         cpu1_irq_o
);
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0]                      lvl;
  logic [NUM_CPU*NUM_SRC-1:0][LINE_W-1:0]  route;
  logic [NUM_CPU-1:0][NUM_LINES-1:0]       lines;

  irq_src_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_q), .async_i(src_irq_i), .sync_o(lvl)
  );

  irq_route_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .addr_i(reg_addr_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .lvl_i(lvl), .route_o(route), .rdata_o(reg_rdata_o)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_fanin #(.NUM_SRC(NUM_SRC), .NMI_LINE(NMI_LINE)) u_fanin (
      .clk(clk), .rst_n(rst_q), .lvl_i(lvl),
      .route_i(route[c*NUM_SRC +: NUM_SRC]),
      .nmi_mask_i(nmi_mask_i[c]), .lines_o(lines[c])
    );
  end

  assign cpu0_irq_o = lines[0];
  assign cpu1_irq_o = lines[1];
endmodule

// File: tb/irq_route_matrix_test.sv
module irq_route_matrix_test;
  localparam int NSRC = 64;
  localparam int NMI  = 14;
  localparam int SBASE = 2*NSRC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NSRC-1:0] src;
  logic [1:0]  nmi;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata, rdata, irq0, irq1;

  always #5 clk = ~clk;

  irq_route_matrix uut (
    .clk(clk), .rst_n(rst_n), .src_irq_i(src), .nmi_mask_i(nmi),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu0_irq_o(irq0), .cpu1_irq_o(irq1)
  );

  typedef struct { string req; int kind; logic [31:0] exp; } item_t;
  item_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;
  int route_m [2][NSRC];

  function automatic logic [31:0] wired();
    logic [31:0] m = '1;
    int internal [6] = '{6, 7, 11, 15, 16, 29};
    foreach (internal[i]) m[internal[i]] = 1'b0;
    return m;
  endfunction

  function automatic logic [31:0] model(int c);
    logic [31:0] r = '0;
    logic [31:0] w = wired();
    for (int s = 0; s < NSRC; s++)
      if (src[s] && w[route_m[c][s]]) r[route_m[c][s]] = 1'b1;
    if (nmi[c]) r[NMI] = 1'b0;
    return r;
  endfunction

  // monitor: pop and compare at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? irq0 : (it.kind == 1) ? irq1 : rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(string req, int kind, logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_lines(string req);
    expect_item(req, 0, model(0));
    expect_item(req, 1, model(1));
  endtask

  task automatic rd(string req, int a, logic [31:0] exp);
    addr = 8'(a);
    expect_item(req, 2, exp);
  endtask

  task automatic route(int c, int s, logic [31:0] v);
    addr = 8'(c*NSRC + s); wdata = v; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    route_m[c][s] = int'(v[4:0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; src = '0; nmi = '0; addr = '0; we = 1'b0; wdata = '0;
    foreach (route_m[c, s]) route_m[c][s] = 6;
    w = wired();
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    expect_item("R1 cpu0 lines", 0, 32'h0);
    expect_item("R1 cpu1 lines", 1, 32'h0);
    rd("R1 route cpu0 s0", 0, 32'd6);
    rd("R1 route cpu1 s63", NSRC + 63, 32'd6);

    // R1/R7: source high but unrouted; status shows it
    src[3] = 1'b1;
    step(3);
    expect_lines("R1 unrouted source stays off");
    rd("R7 status cpu0 w0", SBASE + 0, 32'h0000_0008);
    rd("R7 status cpu1 w0", SBASE + 2, 32'h0000_0008);

    // R8 write and readback, R4 independence
    route(0, 3, 32'd5);
    rd("R8 readback", 3, 32'd5);
    rd("R4 cpu1 route untouched", NSRC + 3, 32'd6);
    step(1);
    expect_item("R8 line after write", 0, 32'h0000_0020);
    expect_item("R4 cpu1 quiet", 1, 32'h0);
    route(1, 3, 32'd22);
    step(1);
    expect_item("R4 cpu0 unchanged", 0, 32'h0000_0020);
    expect_item("R4 cpu1 own route", 1, 32'h0040_0000);

    // R2 sweep over every number, R3 for the internal ones
    for (int n = 0; n < 32; n++) begin
      route(0, 3, 32'(n));
      step(1);
      expect_item(w[n] ? "R2 wired number" : "R3 internal number", 0,
                  w[n] ? (32'h1 << n) : 32'h0);
    end

    // R2 latency: third edge, not second
    route(1, 40, 32'd20);
    src[40] = 1'b1;
    step(2);
    expect_item("R2 not yet at edge 2", 1, 32'h0040_0000);
    step(1);
    expect_item("R2 high at edge 3", 1, 32'h0050_0000);
    rd("R7 status cpu1 w1", SBASE + 3, 32'h0000_0100);

    // R5 sharing
    route(0, 3, 32'd9);
    route(0, 40, 32'd9);
    step(1);
    expect_lines("R5 both high");
    src[3] = 1'b0;
    step(3);
    expect_lines("R5 one remains");
    src[40] = 1'b0;
    step(3);
    expect_lines("R5 all low");

    // R6 masking
    route(0, 10, 32'd14);
    route(0, 11, 32'd2);
    route(1, 10, 32'd14);
    src[10] = 1'b1; src[11] = 1'b1;
    step(3);
    expect_item("R6 before mask", 0, 32'h0000_4004);
    nmi[0] = 1'b1;
    step(1);
    expect_item("R6 masked cpu0", 0, 32'h0000_0004);
    expect_item("R6 cpu1 unaffected", 1, model(1));
    nmi[0] = 1'b0;
    step(1);
    expect_item("R6 released", 0, 32'h0000_4004);

    // R7 status read-only, R8 upper bits
    addr = 8'(SBASE); wdata = 32'hFFFF_FFFF; we = 1'b1;
    step(1);
    we = 1'b0;
    rd("R7 status unchanged", SBASE, 32'h0000_0C00);
    rd("R7 route unchanged", 3, 32'd9);
    route(0, 5, 32'hFFFF_FFE4);
    rd("R8 upper bits zero", 5, 32'd4);
    step(1);
    expect_lines("R2 final lines");

    step(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule